// File: doc/BRIEF.md
# Pipelined binarized neuron accumulator

This block evaluates one fully-connected neuron of a binarized network. Every cycle it can take a vector of single-bit activations together with a vector of single-bit weights of the same length and a signed bias. A bit value of 1 stands for +1 and 0 stands for -1. Each input position contributes the product of its weight and activation: +1 when the two bits agree and -1 when they differ.

The contributions are summed by a balanced adder tree with a register after every level. Each level is one bit wider than the level before it, so the root can hold any total from -N_IN to +N_IN. The bias is captured together with its vector and travels down the tree beside the partial sums. At the root, one last registered stage adds the bias and takes the sign. The result is a single output bit, qualified by a valid strobe that has followed the data through every stage.

The block has no flow control. A new vector may enter on every clock, and results leave in the same order, one per accepted vector.

Top module: `bnn_neuron_acc`

## Requirements
- R1: Input position i contributes +1 when act[i] equals wgt[i] and -1 when they differ, so equal vectors give a sum of +N_IN and complementary vectors give -N_IN.
- R2: For each accepted vector, out_act is 1 when (matches*2 - N_IN) + bias is zero or more and 0 when it is negative, where matches is the number of positions with act[i] equal to wgt[i] and bias is two's complement.
- R3: A biased total of exactly zero gives out_act = 1, and a total of -1 gives out_act = 0.
- R4: out_valid is high for one cycle on the clock edge that comes exactly log2(N_IN)+1 edges after the edge that sampled in_valid high. With the defaults this is 11 edges, counting the sampling edge as the first.
- R5: A vector can be accepted on every clock. Back-to-back vectors produce back-to-back results in arrival order.
- R6: No overflow occurs at the extremes: sums of +N_IN and -N_IN, combined with any bias from the most negative to the most positive value, still give the correct sign.
- R7: act, wgt and bias are sampled only on the edge where in_valid is high. Changes to them on later cycles do not affect that vector's result.
- R8: While out_valid is low, out_act keeps the value of the most recent result. Inputs presented with in_valid low produce no result and leave out_act unchanged.
- R9: An active-low asynchronous reset clears out_valid and out_act to 0 and discards every vector in flight. No result appears after reset until a new vector is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies act, wgt and bias on this edge |
| act | input | N_IN | Binary activations (1 = +1, 0 = -1) |
| wgt | input | N_IN | Binary weights (1 = +1, 0 = -1) |
| bias | input | BIAS_W | Signed two's-complement bias |
| out_valid | output | 1 | Result strobe, one cycle per accepted vector |
| out_act | output | 1 | Sign of biased sum, 1 when zero or more |

## Verification
The checker enforces two rules on every cycle. The fixed latency from in_valid to out_valid is checked against a delay line. out_act is checked to stay stable whenever no result is being delivered. The checker also covers the two saturating corners: vectors that fully agree with a non-negative bias must give 1, and fully complementary vectors with a negative bias must give 0. The bench reference model, compared on every clock, is needed for the rest: correct signs for arbitrary match counts, the exact zero boundary, bias values at the ends of their range, streaming without gaps, and flushing of in-flight work by a mid-stream reset.

// File: rtl/bnn_acc_pkg.sv
package bnn_acc_pkg;

    // Signed product of two binary values, returned as a 2-bit two's-complement value.
    function automatic logic [1:0] pm_product(input logic a, input logic w);
        return (a ~^ w) ? 2'b01 : 2'b11;
    endfunction

endpackage

// File: rtl/bnn_tree_level.sv
module bnn_tree_level #(
    parameter int NO     = 512,
    parameter int IW     = 2,
    parameter int BIAS_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_vld,
    input  logic [2*NO*IW-1:0]       in_sum,
    input  logic signed [BIAS_W-1:0] in_bias,
    output logic                     out_vld,
    output logic [NO*(IW+1)-1:0]     out_sum,
    output logic signed [BIAS_W-1:0] out_bias
);
    localparam int OW = IW + 1;

    typedef struct packed {
        logic                     vld;
        logic signed [BIAS_W-1:0] bias;
        logic [NO*OW-1:0]         sum;
    } lvl_t;

    lvl_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            st_d.bias = in_bias;
            for (int i = 0; i < NO; i++) begin
                st_d.sum[i*OW +: OW] = OW'($signed(in_sum[(2*i)*IW +: IW]))
                                     + OW'($signed(in_sum[(2*i+1)*IW +: IW]));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld  = st_q.vld;
    assign out_sum  = st_q.sum;
    assign out_bias = st_q.bias;
endmodule

// File: rtl/bnn_sign_stage.sv
module bnn_sign_stage #(
    parameter int SUM_W  = 12,
    parameter int BIAS_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_vld,
    input  logic signed [SUM_W-1:0]  in_sum,
    input  logic signed [BIAS_W-1:0] in_bias,
    output logic                     out_vld,
    output logic                     out_act
);
    localparam int TW = ((SUM_W > BIAS_W) ? SUM_W : BIAS_W) + 1;

    typedef struct packed {
        logic vld;
        logic act;
    } sgn_t;

    sgn_t st_d, st_q;
    logic signed [TW-1:0] total;

    always_comb begin
        total    = TW'(in_sum) + TW'(in_bias);
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            st_d.act = ~total[TW-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld = st_q.vld;
    assign out_act = st_q.act;
endmodule

// File: rtl/bnn_neuron_acc.sv
module bnn_neuron_acc #(
    parameter int N_IN   = 1024,
    parameter int BIAS_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [N_IN-1:0]          act,
    input  logic [N_IN-1:0]          wgt,
    input  logic signed [BIAS_W-1:0] bias,
    output logic                     out_valid,
    output logic                     out_act
);
    import bnn_acc_pkg::*;

    localparam int LEVELS = $clog2(N_IN);
    localparam int ROOT_W = LEVELS + 2;

    logic [2*N_IN-1:0] leaf;

    always_comb begin
        for (int i = 0; i < N_IN; i++) begin
            leaf[2*i +: 2] = pm_product(act[i], wgt[i]);
        end
    end

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int IW = l + 2;
        localparam int NO = N_IN >> (l + 1);

        logic [2*NO*IW-1:0]       src;
        logic                     src_vld;
        logic signed [BIAS_W-1:0] src_bias;
        logic [NO*(IW+1)-1:0]     dst;
        logic                     dst_vld;
        logic signed [BIAS_W-1:0] dst_bias;

        if (l == 0) begin : g_first
            assign src      = leaf;
            assign src_vld  = in_valid;
            assign src_bias = bias;
        end else begin : g_next
            assign src      = g_lvl[l-1].dst;
            assign src_vld  = g_lvl[l-1].dst_vld;
            assign src_bias = g_lvl[l-1].dst_bias;
        end

        bnn_tree_level #(.NO(NO), .IW(IW), .BIAS_W(BIAS_W)) u_level (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_vld   (src_vld),
            .in_sum   (src),
            .in_bias  (src_bias),
            .out_vld  (dst_vld),
            .out_sum  (dst),
            .out_bias (dst_bias)
        );
    end

    logic signed [ROOT_W-1:0] root_sum;
    assign root_sum = $signed(g_lvl[LEVELS-1].dst);

    bnn_sign_stage #(.SUM_W(ROOT_W), .BIAS_W(BIAS_W)) u_sign (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (g_lvl[LEVELS-1].dst_vld),
        .in_sum  (root_sum),
        .in_bias (g_lvl[LEVELS-1].dst_bias),
        .out_vld (out_valid),
        .out_act (out_act)
    );
endmodule

// File: rtl/bnn_neuron_acc_chk.sv
module bnn_neuron_acc_chk #(
    parameter int N_IN   = 1024,
    parameter int BIAS_W = 12
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic [N_IN-1:0]          act,
    input logic [N_IN-1:0]          wgt,
    input logic signed [BIAS_W-1:0] bias,
    input logic                     out_valid,
    input logic                     out_act
);
    localparam int LAT = $clog2(N_IN) + 1;

    logic [LAT-1:0] v_hist;
    logic [LAT-1:0] pos_hist;
    logic [LAT-1:0] neg_hist;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_hist   <= '0;
            pos_hist <= '0;
            neg_hist <= '0;
        end else begin
            v_hist   <= {v_hist[LAT-2:0], in_valid};
            pos_hist <= {pos_hist[LAT-2:0], in_valid && (act == wgt) && !bias[BIAS_W-1]};
            neg_hist <= {neg_hist[LAT-2:0], in_valid && (act == ~wgt) && bias[BIAS_W-1]};
        end
    end

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == v_hist[LAT-1]); // R4

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_act)); // R8

    AST_TOP_CORNER: assert property (@(posedge clk) disable iff (!rst_n)
        pos_hist[LAT-1] |-> (out_valid && out_act)); // R6

    AST_BOTTOM_CORNER: assert property (@(posedge clk) disable iff (!rst_n)
        neg_hist[LAT-1] |-> (out_valid && !out_act)); // R6

    AST_KNOWN_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({out_valid, out_act})); // R9
endmodule

bind bnn_neuron_acc bnn_neuron_acc_chk #(.N_IN(N_IN), .BIAS_W(BIAS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .act       (act),
    .wgt       (wgt),
    .bias      (bias),
    .out_valid (out_valid),
    .out_act   (out_act)
);

// File: tb/bnn_neuron_acc_test.sv
module bnn_neuron_acc_test;
    localparam int N     = 1024;
    localparam int BW    = 12;
    localparam int LAT   = 11;
    localparam int CLK_P = 10;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic [N-1:0]         act = '0;
    logic [N-1:0]         wgt = '0;
    logic signed [BW-1:0] bias = '0;
    logic                 out_valid;
    logic                 out_act;

    int    checks = 0;
    int    failures = 0;
    bit    done = 0;
    bit    run_chk = 0;
    string cur_req = "R2";

    bit exp_v [LAT];
    bit exp_a [LAT];
    bit exp_act = 0;

    bnn_neuron_acc #(.N_IN(N), .BIAS_W(BW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .act(act), .wgt(wgt),
        .bias(bias), .out_valid(out_valid), .out_act(out_act)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic bit ref_sign(input logic [N-1:0] a, input logic [N-1:0] w,
                                    input logic signed [BW-1:0] b);
        int m = 0;
        for (int i = 0; i < N; i++) if (a[i] == w[i]) m++;
        return ((2*m - N + int'(b)) >= 0);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int actual, input int expected);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, actual, expected, $time);
        end
    endtask

    // Reference model: a plain delay line of expected results.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) begin exp_v[i] = 0; exp_a[i] = 0; end
            exp_act = 0;
        end else begin
            for (int i = LAT-1; i > 0; i--) begin exp_v[i] = exp_v[i-1]; exp_a[i] = exp_a[i-1]; end
            exp_v[0] = in_valid;
            exp_a[0] = in_valid ? ref_sign(act, wgt, bias) : 1'b0;
            if (exp_v[LAT-1]) exp_act = exp_a[LAT-1];
        end
    end

    always @(negedge clk) begin
        if (rst_n && run_chk) begin
            check(out_valid === exp_v[LAT-1], cur_req, "out_valid", int'(out_valid), int'(exp_v[LAT-1]));
            check(out_act === exp_act, cur_req, "out_act", int'(out_act), int'(exp_act));
        end
    end

    function automatic logic [N-1:0] rand_vec();
        logic [N-1:0] v;
        for (int i = 0; i < N; i += 32) v[i +: 32] = $urandom();
        return v;
    endfunction

    // Present a vector whose weights differ from the activations in k positions.
    task automatic send_k(input int k, input logic signed [BW-1:0] b);
        logic [N-1:0] a = rand_vec();
        logic [N-1:0] w = a;
        for (int i = 0; i < k; i++) w[(i * 7) % N] = ~w[(i * 7) % N];
        @(negedge clk);
        in_valid = 1'b1; act = a; wgt = w; bias = b;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; act = rand_vec(); wgt = rand_vec(); bias = BW'($urandom());
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R9", "reset out_valid", int'(out_valid), 0);
        check(out_act === 1'b0, "R9", "reset out_act", int'(out_act), 0);
        rst_n = 1'b1;
        run_chk = 1;

        // R1/R2: full agreement and full disagreement
        cur_req = "R1";
        send_k(0, 0);    idle(LAT + 1);
        send_k(N, 0);    idle(LAT + 1);
        cur_req = "R2";
        send_k(100, -5); send_k(700, 300); send_k(300, -400); idle(LAT + 1);

        // R3: zero boundary
        cur_req = "R3";
        send_k(N/2, 0); send_k(N/2 + 1, 1); send_k(N/2 + 1, 2); send_k(N/2, -1); idle(LAT + 1);

        // R6: extremes of sum and bias
        cur_req = "R6";
        send_k(0, -1024); send_k(0, -1025); send_k(0, 2047); send_k(N, 2047);
        send_k(N, -2048); send_k(0, -2048); send_k(N, 1024); send_k(N, 1023); idle(LAT + 1);

        // R4: latency counted in edges
        cur_req = "R4";
        send_k(0, 0);
        begin
            int cnt = 0;
            do begin
                @(negedge clk);
                in_valid = 1'b0;
                cnt++;
            end while (!out_valid && cnt < 40);
            check(cnt == LAT, "R4", "latency", cnt, LAT);
        end
        idle(3);

        // R5: streaming every cycle
        cur_req = "R5";
        for (int j = 0; j < 60; j++) send_k($urandom_range(N/2 - 40, N/2 + 40), BW'($signed($urandom_range(0, 80)) - 40));
        idle(LAT + 1);

        // R7/R8: gaps with random ignored data
        cur_req = "R7";
        for (int j = 0; j < 20; j++) begin
            send_k($urandom_range(0, N), BW'($urandom()));
            idle($urandom_range(1, 4));
        end
        cur_req = "R8";
        idle(LAT + 10);

        // R9: reset flushes work in flight
        cur_req = "R9";
        for (int j = 0; j < 5; j++) send_k(0, 0);
        idle(2);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check(out_valid === 1'b0, "R9", "out_valid in reset", int'(out_valid), 0);
        check(out_act === 1'b0, "R9", "out_act in reset", int'(out_act), 0);
        @(negedge clk); rst_n = 1'b1;
        idle(LAT + 4);
        send_k(N, 5); idle(LAT + 2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule